// File: doc/BRIEF.md
# PWM Action Qualifier

This block turns counter and compare events into two pulse-width-modulated outputs, A and B. An external time base supplies the counter value, its count direction, the period and two compare values. Each clock the block finds which events are present: counter at zero, counter at period, and compare A or compare B matched while counting up or while counting down. For each output a programmable table of two-bit actions maps every event to no action, drive low, drive high or invert. When several events coincide, a fixed ordering based on position in the counting sequence picks one action per output.

Software controls override the event table. A one-shot request applies a chosen action to an output for one clock. A continuous force holds an output low or high until it is released. It is written through a shadow register, and the shadow is copied to the active register either at once or at a selectable counter point. Both outputs are registered. Every clock is one counter step.

Top module: `pwm_action_qual`

## Requirements
- R1: While reset is high, both outputs go low and both continuous forces, active and shadow, return to released (00).
- R2: Action codes are 00 none, 01 drive low, 10 drive high, 11 invert. In each 12-bit action table, bits [1:0] are zero, [3:2] period, [5:4] compare A up, [7:6] compare A down, [9:8] compare B up, [11:10] compare B down.
- R3: A compare match makes only its up event when the direction input is 1, and only its down event when it is 0.
- R4: Each output has its own action table, and any event may act on either output. For example, a compare B event can drive output A.
- R5: When counting up, coinciding events rank period over compare B up, over compare A up, over zero. The highest-ranked present event whose action is not none is applied.
- R6: When counting down, coinciding events rank zero over compare B down, over compare A down, over period, with the same non-none rule.
- R7: A compare value greater than the period makes no compare event, even when the counter equals it.
- R8: A one-shot request pulse applies its own two-bit action to its output at that clock edge, in place of any event action. It has no effect in the following cycle.
- R9: Continuous force code 01 holds the output low and 10 holds it high, over both events and one-shot requests. Codes 00 and 11 release the output.
- R10: With load select 11 (immediate), a force written in one cycle sets the output at that same clock edge.
- R11: With load select 00 (zero), 01 (period) or 10 (either), a write goes to the shadow. The shadow is copied to the active force at the first later edge where the counter meets the chosen point, and the output follows at the next edge.
- R12: With no event action, no one-shot request and no force, each output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | W | Time-base counter value |
| prd | input | W | Period value |
| cmp_a | input | W | Compare A value |
| cmp_b | input | W | Compare B value |
| cnt_up | input | 1 | Count direction, 1 = up |
| act_a | input | 12 | Event action table for output A |
| act_b | input | 12 | Event action table for output B |
| os_go_a | input | 1 | One-shot request for output A |
| os_go_b | input | 1 | One-shot request for output B |
| os_act_a | input | 2 | One-shot action for output A |
| os_act_b | input | 2 | One-shot action for output B |
| csf_wr | input | 1 | Continuous force write strobe |
| csf_val_a | input | 2 | Continuous force value for output A |
| csf_val_b | input | 2 | Continuous force value for output B |
| csf_ld | input | 2 | Force load select |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
Event actions, one-shot requests and immediate forces all reach the outputs at the rising edge where their inputs are sampled. A shadowed force arrives one edge later than the load-point edge. The bench changes inputs on the falling edge and steps a behavioural model on each rising edge using the values it drove. It then compares both outputs with the model on the next falling edge. The model therefore carries the one-edge delay of the shadow copy in its own state, and nothing is sampled at an edge.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int NEV     = 6;
    localparam int EV_ZERO = 0;
    localparam int EV_PRD  = 1;
    localparam int EV_CAU  = 2;
    localparam int EV_CAD  = 3;
    localparam int EV_CBU  = 4;
    localparam int EV_CBD  = 5;
    localparam int CFG_W   = 2 * NEV;
    localparam int NRANK   = 4;

    typedef logic [NEV-1:0]   ev_t;
    typedef logic [CFG_W-1:0] cfg_t;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_INV  = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        LD_ZERO = 2'b00,
        LD_PRD  = 2'b01,
        LD_BOTH = 2'b10,
        LD_IMM  = 2'b11
    } ld_e;

    // ranking, index 0 is the strongest
    localparam int RANK_UP [NRANK] = '{EV_PRD, EV_CBU, EV_CAU, EV_ZERO};
    localparam int RANK_DN [NRANK] = '{EV_ZERO, EV_CBD, EV_CAD, EV_PRD};

    function automatic logic apply_act(logic cur, logic [1:0] a);
        case (act_e'(a))
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_INV:  return ~cur;
            default:  return cur;
        endcase
    endfunction

    // walk from weakest to strongest so the strongest non-none wins
    function automatic logic [1:0] pick_act(ev_t ev, cfg_t cfg, logic up);
        logic [1:0] r;
        int         k;
        r = ACT_NONE;
        for (int i = NRANK - 1; i >= 0; i--) begin
            k = up ? RANK_UP[i] : RANK_DN[i];
            if (ev[k] && (cfg[2*k +: 2] != 2'b00))
                r = cfg[2*k +: 2];
        end
        return r;
    endfunction

endpackage

// File: rtl/aq_event_decode.sv
module aq_event_decode
    import pwm_aq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] prd,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         cnt_up,
    output ev_t          ev
);
    localparam int NCMP = 2;

    logic [W-1:0] cmp_v [NCMP];
    assign cmp_v[0] = cmp_a;
    assign cmp_v[1] = cmp_b;

    assign ev[EV_ZERO] = (cnt == '0);
    assign ev[EV_PRD]  = (cnt == prd);

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        logic hit;
        assign hit = (cnt == cmp_v[g]) && (cmp_v[g] <= prd);
        assign ev[EV_CAU + 2*g] = hit & cnt_up;
        assign ev[EV_CAD + 2*g] = hit & ~cnt_up;
    end
endmodule

// File: rtl/aq_force_reg.sv
module aq_force_reg
    import pwm_aq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] val,
    input  ld_e        ld,
    input  logic       at_zero,
    input  logic       at_prd,
    output logic [1:0] eff,
    output logic [1:0] active
);
    logic [1:0] shadow;
    logic       load_pt;
    logic       imm_wr;

    always_comb begin
        case (ld)
            LD_ZERO: load_pt = at_zero;
            LD_PRD:  load_pt = at_prd;
            LD_BOTH: load_pt = at_zero | at_prd;
            default: load_pt = 1'b0;
        endcase
    end

    assign imm_wr = wr && (ld == LD_IMM);
    assign eff    = imm_wr ? val : active;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= 2'b00;
            active <= 2'b00;
        end else begin
            if (wr)
                shadow <= val;
            if (imm_wr)
                active <= val;
            else if (load_pt)
                active <= shadow;
        end
    end
endmodule

// File: rtl/aq_out_path.sv
module aq_out_path
    import pwm_aq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ev_t        ev,
    input  logic       cnt_up,
    input  cfg_t       cfg,
    input  logic       os_go,
    input  logic [1:0] os_act,
    input  logic [1:0] force_eff,
    output logic       q
);
    logic       nxt;
    logic [1:0] ev_act;

    assign ev_act = pick_act(ev, cfg, cnt_up);

    always_comb begin
        case (act_e'(force_eff))
            ACT_LOW:  nxt = 1'b0;
            ACT_HIGH: nxt = 1'b1;
            default:  nxt = os_go ? apply_act(q, os_act) : apply_act(q, ev_act);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= nxt;
    end
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
    import pwm_aq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] prd,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         cnt_up,
    input  logic [11:0]  act_a,
    input  logic [11:0]  act_b,
    input  logic         os_go_a,
    input  logic         os_go_b,
    input  logic [1:0]   os_act_a,
    input  logic [1:0]   os_act_b,
    input  logic         csf_wr,
    input  logic [1:0]   csf_val_a,
    input  logic [1:0]   csf_val_b,
    input  logic [1:0]   csf_ld,
    output logic         pwm_a,
    output logic         pwm_b
);
    localparam int NOUT = 2;

    ev_t        ev_vec;
    cfg_t       cfg_v   [NOUT];
    logic       os_go_v [NOUT];
    logic [1:0] os_act_v[NOUT];
    logic [1:0] val_v   [NOUT];
    logic [1:0] eff_v   [NOUT];
    logic [1:0] act_v   [NOUT];
    logic       q_v     [NOUT];
    logic [1:0] force_a;
    logic [1:0] force_b;

    assign cfg_v[0]    = act_a;
    assign cfg_v[1]    = act_b;
    assign os_go_v[0]  = os_go_a;
    assign os_go_v[1]  = os_go_b;
    assign os_act_v[0] = os_act_a;
    assign os_act_v[1] = os_act_b;
    assign val_v[0]    = csf_val_a;
    assign val_v[1]    = csf_val_b;

    aq_event_decode #(.W(W)) u_dec (
        .cnt    (cnt),
        .prd    (prd),
        .cmp_a  (cmp_a),
        .cmp_b  (cmp_b),
        .cnt_up (cnt_up),
        .ev     (ev_vec)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        aq_force_reg u_force (
            .clk     (clk),
            .rst     (rst),
            .wr      (csf_wr),
            .val     (val_v[g]),
            .ld      (ld_e'(csf_ld)),
            .at_zero (ev_vec[EV_ZERO]),
            .at_prd  (ev_vec[EV_PRD]),
            .eff     (eff_v[g]),
            .active  (act_v[g])
        );

        aq_out_path u_path (
            .clk       (clk),
            .rst       (rst),
            .ev        (ev_vec),
            .cnt_up    (cnt_up),
            .cfg       (cfg_v[g]),
            .os_go     (os_go_v[g]),
            .os_act    (os_act_v[g]),
            .force_eff (eff_v[g]),
            .q         (q_v[g])
        );
    end

    assign force_a = act_v[0];
    assign force_b = act_v[1];
    assign pwm_a   = q_v[0];
    assign pwm_b   = q_v[1];
endmodule

// File: rtl/pwm_aq_checker.sv
module pwm_aq_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_up,
    input logic [W-1:0] cmp_a,
    input logic [W-1:0] prd,
    input logic [5:0]   ev_vec,
    input logic [1:0]   force_a,
    input logic [1:0]   force_b,
    input logic         csf_wr,
    input logic [1:0]   csf_ld,
    input logic [1:0]   csf_val_a,
    input logic [1:0]   csf_val_b,
    input logic         os_go_a,
    input logic [1:0]   os_act_a,
    input logic         pwm_a,
    input logic         pwm_b
);
    logic imm_a, imm_b, held_a;
    assign imm_a  = csf_wr && (csf_ld == 2'b11);
    assign imm_b  = imm_a;
    assign held_a = (force_a == 2'b01) || (force_a == 2'b10);

    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> (!pwm_a && !pwm_b));

    assert_dir_qual_R3: assert property (@(posedge clk) disable iff (rst)
        !cnt_up |-> (!ev_vec[2] && !ev_vec[4]));

    assert_cmp_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (cmp_a > prd) |-> (!ev_vec[2] && !ev_vec[3]));

    assert_oneshot_inv_R8: assert property (@(posedge clk) disable iff (rst)
        (os_go_a && os_act_a == 2'b11 && !held_a && !imm_a) |=> (pwm_a != $past(pwm_a)));

    assert_force_low_R9: assert property (@(posedge clk) disable iff (rst)
        (force_a == 2'b01 && !imm_a) |=> !pwm_a);

    assert_force_high_R9: assert property (@(posedge clk) disable iff (rst)
        (force_b == 2'b10 && !imm_b) |=> pwm_b);

    assert_imm_force_R10: assert property (@(posedge clk) disable iff (rst)
        (imm_a && csf_val_a == 2'b10) |=> pwm_a);

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (ev_vec == 6'b0 && !os_go_a && !held_a && !imm_a) |=> $stable(pwm_a));
endmodule

bind pwm_action_qual pwm_aq_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_up    (cnt_up),
    .cmp_a     (cmp_a),
    .prd       (prd),
    .ev_vec    (ev_vec),
    .force_a   (force_a),
    .force_b   (force_b),
    .csf_wr    (csf_wr),
    .csf_ld    (csf_ld),
    .csf_val_a (csf_val_a),
    .csf_val_b (csf_val_b),
    .os_go_a   (os_go_a),
    .os_act_a  (os_act_a),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b)
);

// File: tb/pwm_action_qual_tb.sv
module pwm_action_qual_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cnt = '0, prd = 16'd9, cmp_a = '0, cmp_b = '0;
    logic         cnt_up = 1'b1;
    logic [11:0]  act_a = '0, act_b = '0;
    logic         os_go_a = 1'b0, os_go_b = 1'b0;
    logic [1:0]   os_act_a = '0, os_act_b = '0;
    logic         csf_wr = 1'b0;
    logic [1:0]   csf_val_a = '0, csf_val_b = '0, csf_ld = '0;
    logic         pwm_a, pwm_b;

    pwm_action_qual #(.W(W)) u_dut (.*);

    always #5 clk = ~clk;

    int    errors = 0, checks = 0, cycles = 0;
    string tag = "R1";
    bit    done = 0;

    // reference model state
    bit ea = 0, eb = 0;
    int sh [2] = '{0, 0};
    int ac [2] = '{0, 0};
    int rank_up [4] = '{1, 4, 2, 0};   // period, B up, A up, zero
    int rank_dn [4] = '{0, 5, 3, 1};   // zero, B down, A down, period

    function automatic bit model_next(bit cur, bit [11:0] tbl, bit [5:0] ev, bit up,
                                      bit osg, bit [1:0] osa, int f);
        bit [1:0] a;
        if (f == 1) return 1'b0;
        if (f == 2) return 1'b1;
        a = 2'b00;
        if (osg) a = osa;
        else begin
            for (int i = 0; i < 4; i++) begin
                int k;
                k = up ? rank_up[i] : rank_dn[i];
                if (ev[k] && tbl[2*k +: 2] != 2'b00) begin
                    a = tbl[2*k +: 2];
                    break;
                end
            end
        end
        case (a)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ea = 0; eb = 0;
            sh[0] = 0; sh[1] = 0; ac[0] = 0; ac[1] = 0;
        end else begin
            bit [5:0] ev;
            bit       lp;
            int       fa, fb;
            int       na, nb;
            ev[0] = (cnt == 0);
            ev[1] = (cnt == prd);
            ev[2] = cnt_up  && cnt == cmp_a && cmp_a <= prd;
            ev[3] = !cnt_up && cnt == cmp_a && cmp_a <= prd;
            ev[4] = cnt_up  && cnt == cmp_b && cmp_b <= prd;
            ev[5] = !cnt_up && cnt == cmp_b && cmp_b <= prd;
            fa = (csf_wr && csf_ld == 3) ? int'(csf_val_a) : ac[0];
            fb = (csf_wr && csf_ld == 3) ? int'(csf_val_b) : ac[1];
            ea = model_next(ea, act_a, ev, cnt_up, os_go_a, os_act_a, fa);
            eb = model_next(eb, act_b, ev, cnt_up, os_go_b, os_act_b, fb);
            case (csf_ld)
                2'd0: lp = ev[0];
                2'd1: lp = ev[1];
                2'd2: lp = ev[0] | ev[1];
                default: lp = 0;
            endcase
            na = csf_val_a; nb = csf_val_b;
            if (csf_wr && csf_ld == 3) begin ac[0] = na; ac[1] = nb; end
            else if (lp) begin ac[0] = sh[0]; ac[1] = sh[1]; end
            if (csf_wr) begin sh[0] = na; sh[1] = nb; end
        end
    end

    task automatic check(bit act, bit exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(pwm_a, ea, "pwm_a");
            check(pwm_b, eb, "pwm_b");
        end
    end

    // counter driver
    int mode = 0;     // 0 up, 1 down, 2 up-down, 3 held by hand
    int c = 0;
    bit going_up = 1;

    task automatic tick();
        @(negedge clk);
        os_go_a = 0; os_go_b = 0; csf_wr = 0;
        case (mode)
            0: begin c = (c >= int'(prd)) ? 0 : c + 1; going_up = 1; end
            1: begin c = (c == 0 || c > int'(prd)) ? int'(prd) : c - 1; going_up = 0; end
            2: begin
                if (going_up) begin
                    if (c >= int'(prd)) begin going_up = 0; c = c - 1; end else c = c + 1;
                end else begin
                    if (c == 0) begin going_up = 1; c = 1; end else c = c - 1;
                end
            end
            default: ;
        endcase
        cnt = W'(c);
        cnt_up = going_up;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        // R1: reset
        tag = "R1";
        repeat (3) @(negedge clk);
        check(pwm_a, 1'b0, "reset pwm_a");
        check(pwm_b, 1'b0, "reset pwm_b");
        rst = 0;

        // R2,R4: up count, compare B drives output A, codes and field layout
        tag = "R2,R4";
        mode = 0; prd = 9; cmp_a = 3; cmp_b = 6;
        act_a = 12'h102;   // zero high, compare B up low
        act_b = 12'h02C;   // compare A up high, period invert
        run(25);
        act_a = 12'h003;   // zero invert
        run(25);

        // R3: up-down with direction-qualified actions
        tag = "R3";
        mode = 2; cmp_a = 4; cmp_b = 7;
        act_a = 12'h060;   // A up high, A down low
        act_b = 12'h300;   // B up invert only
        run(40);

        // R5: coinciding events while counting up
        tag = "R5";
        mode = 0; cmp_a = 5; cmp_b = 5;
        act_a = 12'h120;   // A up high vs B up low
        act_b = 12'h000;
        run(22);
        cmp_a = 0; cmp_b = 9;
        act_a = 12'h021;   // zero low vs A up high
        act_b = 12'h204;   // B up high vs period low
        run(22);

        // R6: coinciding events while counting down
        tag = "R6";
        mode = 1; cmp_a = 4; cmp_b = 4;
        act_a = 12'h480;   // A down high vs B down low
        act_b = 12'hC08;   // B down invert, period high
        run(22);
        cmp_a = 9; cmp_b = 0;
        act_a = 12'h048;   // A down low vs period high
        act_b = 12'h402;   // zero high vs B down low
        run(22);

        // R7: compare above period, counter driven onto it by hand
        tag = "R7";
        mode = 3; prd = 9; cmp_a = 20; cmp_b = 15;
        act_a = 12'h030; act_b = 12'h300;
        c = 20; going_up = 1; run(4);
        c = 15; run(4);
        going_up = 0; c = 20; act_a = 12'h0C0; act_b = 12'hC00; run(4);
        prd = 9;

        // R8: one-shot requests over running events
        tag = "R8";
        mode = 0; cmp_a = 3; cmp_b = 6;
        act_a = 12'h102; act_b = 12'h02C;
        run(5);
        os_go_a = 1; os_act_a = 2'b11; run(1);
        run(3);
        os_go_a = 1; os_act_a = 2'b10; os_go_b = 1; os_act_b = 2'b01; run(1);
        for (int i = 0; i < 6; i++) begin
            os_go_b = 1; os_act_b = 2'b11; run(2);
        end
        run(10);

        // R9,R10: immediate continuous forces
        tag = "R9,R10";
        csf_ld = 2'b11;
        csf_wr = 1; csf_val_a = 2'b01; csf_val_b = 2'b10; run(1);
        os_go_a = 1; os_act_a = 2'b10; run(1);
        run(14);
        csf_wr = 1; csf_val_a = 2'b10; csf_val_b = 2'b00; run(1);
        run(14);
        csf_wr = 1; csf_val_a = 2'b11; csf_val_b = 2'b00; run(1);
        run(14);

        // R11: shadowed forces at zero, period, either
        tag = "R11";
        csf_ld = 2'b00;
        csf_wr = 1; csf_val_a = 2'b10; csf_val_b = 2'b01; run(1);
        run(24);
        csf_ld = 2'b01;
        csf_wr = 1; csf_val_a = 2'b01; csf_val_b = 2'b10; run(1);
        run(24);
        csf_ld = 2'b10;
        csf_wr = 1; csf_val_a = 2'b00; csf_val_b = 2'b00; run(1);
        run(24);

        // R12: nothing configured, outputs hold
        tag = "R12";
        act_a = 12'h000; act_b = 12'h000;
        mode = 2;
        run(30);

        finish_run();
    end
endmodule